// File: doc/BRIEF.md
# Falling-Edge Triggered Programmable Pulse Generator

This block watches a single-bit strobe input and produces one output pulse for each falling edge it accepts. It detects the edge by comparing the strobe against its value on the previous clock edge. The output pulse begins a fixed two cycles after the edge is detected. It then stays high for a base of 70 cycles plus an 8-bit offset, which software may change between pulses.

The offset is captured on the same clock edge that detects the falling edge of the strobe. A change to the offset after that edge leaves the pulse in flight untouched. A busy flag covers the start delay and the whole high period. Falling edges that arrive while busy is high are dropped and are not queued.

All pins are plain control and status signals. No data stream crosses the boundary, so the block has no valid/ready handshake and no back-pressure.

Top module: `fall_pulse_gen`

## Requirements
- R1: If the strobe is sampled high at clock edge k-1 and low at edge k while busy is low, the pulse output is low and busy is high between edges k and k+1. The pulse output is first high between edges k+1 and k+2, so it is sampled high at edge k+2.
- R2: Once it has started, the pulse output stays high for exactly 70 + offset consecutive clock cycles. It is low on the cycle right after the last high cycle.
- R3: An offset of 0 gives a pulse exactly 70 cycles wide.
- R4: An offset of 255, the largest value of the unsigned 8-bit input, gives a pulse exactly 325 cycles wide.
- R5: The offset used for a pulse is the value present on the edge that detects the strobe falling. Later changes to the offset input do not alter that pulse's width.
- R6: Busy is high from the edge after detection through the last high cycle of the pulse, and it falls together with the pulse. A falling strobe edge seen while busy is high starts no pulse, either during or after the current one.
- R7: Edges are judged only against the previous sample. A strobe that is held low, or that rises, starts no pulse.
- R8: A synchronous active-high reset drives the pulse output and busy low on the next edge. It also clears the edge history, the offset latch and the counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strobe_i | input | 1 | Trigger strobe; a falling edge requests a pulse |
| offset_i | input | 8 | Unsigned extra width added to the 70-cycle base |
| pulse_o | output | 1 | Generated pulse |
| busy_o | output | 1 | High while a pulse is pending or in progress |

## Verification
The embedded properties check the following on every cycle:
- the two-cycle start after an accepted edge;
- that the counted high time of each pulse equals 70 plus the latched offset;
- that the latched offset stays fixed while busy is high;
- that the pulse never appears without busy;
- that reset clears both outputs.

Some behaviours can only be shown by the bench's scenarios, because they concern what the ports do rather than internal consistency:
- that the width matches the offset as it was on the input pins, and not a later value;
- that falls arriving while busy leave no trace afterwards;
- that a strobe held low or rising starts nothing;
- the extreme widths at offsets 0 and 255.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef enum logic [1:0] {
    PG_IDLE = 2'd0,
    PG_WAIT = 2'd1,
    PG_HIGH = 2'd2
  } pg_state_e;
endpackage

// File: rtl/pg_fall_detect.sv
module pg_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic fall_o
);
  logic hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= sig_i;
  end

  assign fall_o = hist_q & ~sig_i;

  // R7
  fall_hist_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |-> ($past(sig_i) && !sig_i));
endmodule

// File: rtl/pg_down_ctr.sv
module pg_down_ctr #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                          cnt_q <= '0;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R2
  ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run_i && !load_i && !done_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/fall_pulse_gen.sv
module fall_pulse_gen #(
  parameter int BASE_LEN  = 70,
  parameter int OFF_W     = 8,
  parameter int START_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic             pulse_o,
  output logic             busy_o
);
  import pg_pkg::*;

  localparam int MAX_LEN = BASE_LEN + (1 << OFF_W) - 1;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int DLY_W   = (START_LAT > 2) ? $clog2(START_LAT) : 1;

  pg_state_e        state_q;
  logic [OFF_W-1:0] off_q;
  logic             pulse_q;
  logic             fall;
  logic             accept;
  logic             dly_done;
  logic             wid_done;
  logic             wid_load;
  logic [CNT_W-1:0] wid_val;

  pg_fall_detect u_edge (
    .clk    (clk),
    .rst    (rst),
    .sig_i  (strobe_i),
    .fall_o (fall)
  );

  assign accept   = fall && (state_q == PG_IDLE);
  assign wid_load = (state_q == PG_WAIT) && dly_done;
  assign wid_val  = CNT_W'(BASE_LEN) + CNT_W'(off_q) - 1'b1;

  pg_down_ctr #(.W(DLY_W)) u_delay (
    .clk        (clk),
    .rst        (rst),
    .load_i     (accept),
    .load_val_i (DLY_W'(START_LAT - 2)),
    .run_i      (state_q == PG_WAIT),
    .done_o     (dly_done)
  );

  pg_down_ctr #(.W(CNT_W)) u_width (
    .clk        (clk),
    .rst        (rst),
    .load_i     (wid_load),
    .load_val_i (wid_val),
    .run_i      (state_q == PG_HIGH),
    .done_o     (wid_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PG_IDLE;
      off_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      case (state_q)
        PG_IDLE: if (accept) begin
          state_q <= PG_WAIT;
          off_q   <= offset_i;
        end
        PG_WAIT: if (dly_done) begin
          state_q <= PG_HIGH;
          pulse_q <= 1'b1;
        end
        PG_HIGH: if (wid_done) begin
          state_q <= PG_IDLE;
          pulse_q <= 1'b0;
        end
        default: state_q <= PG_IDLE;
      endcase
    end
  end

  assign pulse_o = pulse_q;
  assign busy_o  = (state_q != PG_IDLE);

  // Assertion-only high-time tally
  logic [CNT_W:0] hi_len_q;
  always_ff @(posedge clk) begin
    if (rst)          hi_len_q <= '0;
    else if (pulse_o) hi_len_q <= hi_len_q + 1'b1;
    else              hi_len_q <= '0;
  end

  // R1
  start_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && !$past(rst)) |-> ##2 $rose(pulse_o));

  // R2
  width_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(pulse_o) && !$past(rst)) |->
      (hi_len_q == (CNT_W+1)'(BASE_LEN) + (CNT_W+1)'(off_q)));

  // R5
  offset_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(off_q));

  // R6
  pulse_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> busy_o);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!pulse_o && !busy_o));
endmodule

// File: tb/test_fall_pulse_gen.sv
`timescale 1ns/1ps
module test_fall_pulse_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       strobe;
  logic [7:0] offset;
  logic       pulse;
  logic       busy;
  int         errors = 0;
  int         checks = 0;

  always #2 clk = ~clk;

  fall_pulse_gen i_fall_pulse_gen (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (strobe),
    .offset_i (offset),
    .pulse_o  (pulse),
    .busy_o   (busy)
  );

  // {offset at fall, offset driven afterwards, fall during busy, expected width}
  localparam logic [25:0] VEC [5] = '{
    {8'd0,   8'd200, 1'b0, 9'd70},
    {8'd255, 8'd0,   1'b0, 9'd325},
    {8'd17,  8'd3,   1'b1, 9'd87},
    {8'd1,   8'd0,   1'b0, 9'd71},
    {8'd100, 8'd255, 1'b1, 9'd170}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_pulse(input logic [7:0] off, input logic [7:0] late,
                           input bit glitch, input int exp_w);
    int w;
    bit seen;
    @(negedge clk) begin strobe = 1'b1; offset = off; end
    @(negedge clk) strobe = 1'b0;
    @(negedge clk);
    // R1: detected at previous edge; pulse low and busy high now
    check(!pulse && busy, "R1 delay phase", {30'd0, pulse, busy}, 1);
    offset = late;  // R5: change after capture
    if (glitch) strobe = 1'b1;
    @(negedge clk);
    check(pulse == 1'b1, "R1 start", pulse, 1);
    if (glitch) strobe = 1'b0;  // R6: fall while busy
    w = 1;
    while (pulse && w < 400) begin
      @(negedge clk);
      if (pulse) w++;
    end
    check(w == exp_w, "R2/R3/R4/R5 width", w, exp_w);
    check(!busy, "R6 busy drops with pulse", busy, 0);
    if (glitch) begin
      seen = 1'b0;
      repeat (6) begin
        @(negedge clk);
        if (pulse || busy) seen = 1'b1;
      end
      check(!seen, "R6 fall during busy ignored", seen, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit seen;
    rst = 1'b1; strobe = 1'b0; offset = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8: reset state
    check(!pulse && !busy, "R8 reset state", {30'd0, pulse, busy}, 0);

    for (int i = 0; i < 5; i++)
      run_pulse(VEC[i][25:18], VEC[i][17:10], VEC[i][9], int'(VEC[i][8:0]));

    // R7: strobe held low, then rising and held high
    seen = 1'b0;
    repeat (10) begin @(negedge clk); if (pulse || busy) seen = 1'b1; end
    check(!seen, "R7 held low", seen, 0);
    strobe = 1'b1;
    repeat (10) begin @(negedge clk); if (pulse || busy) seen = 1'b1; end
    check(!seen, "R7 rising edge", seen, 0);

    // R8: reset in the middle of a pulse
    @(negedge clk) begin strobe = 1'b0; offset = 8'd50; end
    repeat (12) @(negedge clk);
    check(pulse == 1'b1, "R8 pulse running before reset", pulse, 1);
    rst = 1'b1;
    @(negedge clk);
    check(!pulse && !busy, "R8 mid-pulse reset", {30'd0, pulse, busy}, 0);
    rst = 1'b0;
    seen = 1'b0;
    repeat (5) begin @(negedge clk); if (pulse || busy) seen = 1'b1; end
    check(!seen, "R8 history cleared", seen, 0);

    // R2: pulse works again after reset
    run_pulse(8'd5, 8'd9, 1'b0, 75);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule